// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for every beat of a four-beat burst in a synchronous memory. A base address is captured on a load strobe. The upper bits of that address stay fixed for the whole burst. The two low bits are formed from a beat counter combined with the captured starting offset, in one of two orders.

The order input selects the sequence. In interleaved order the low bits are the start offset XOR the beat number. In linear order they are the start offset plus the beat number, modulo four. The order input is a static strap and is changed only while the block is held in reset.

An active-low advance input steps the burst to its next beat. Holding advance high gives a wait cycle, and the address does not move. A new load may arrive at any beat and starts a fresh burst. The address output is registered and shows the effect of an edge one clock after that edge.

Top module: `abg_burst_addr`

## Requirements
- R1: Between loads, addr_out[14:2] keep the value of addr_in[14:2] captured by the last load, whatever addr_in does.
- R2: With ilv_mode = 1, addr_out[1:0] equals the start offset XOR the beat number. A start of 01 gives the sequence 01, 00, 11, 10.
- R3: With ilv_mode = 0, addr_out[1:0] equals (start offset + beat number) mod 4. A start of 01 gives the sequence 01, 10, 11, 00.
- R4: The step after the fourth beat wraps back to the starting address of the burst.
- R5: An edge with adv_n = 0 and ld = 0 moves to the next beat. An edge with adv_n = 1 and ld = 0 leaves addr_out unchanged.
- R6: A load during a burst abandons that burst and restarts from the new base address.
- R7: A load takes priority over an advance on the same edge and sets the beat number to zero. The next advance produces beat 1 of the new burst.
- R8: The edge that samples ld = 1 presents addr_in on addr_out just after that edge.
- R9: A synchronous rst = 1 clears addr_out and the beat number to zero and takes priority over ld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Capture addr_in as a new burst base |
| adv_n | input | 1 | Active-low step to the next beat |
| ilv_mode | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | 15 | External base address |
| addr_out | output | 15 | Current burst address, registered |

## Verification
The hardest cases to reach are an edge that carries both a load and an advance, and a load that arrives in the middle of a burst after the count has already moved. The stimulus table builds partial bursts with wait cycles mixed in. It then fires a load with advance still low and checks both the restarted base and the following beat. The table also drives a reset that coincides with a load. It then advances once without any load, which shows at the port that the beat count was cleared.

// File: rtl/abg_pkg.sv
package abg_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/abg_beat_cnt.sv
module abg_beat_cnt #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             adv_n,
  output logic [OFS_W-1:0] beat_d,
  output logic [OFS_W-1:0] beat_q
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  always_comb begin
    if (ld)          beat_d = '0;
    else if (!adv_n) beat_d = beat_q + ONE;
    else             beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end

  AST_BEAT_ZERO_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (beat_q == '0)); // R7
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n) |=> (beat_q == $past(beat_q) + ONE)); // R5
  AST_BEAT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> $stable(beat_q)); // R5
endmodule

// File: rtl/abg_ofs_map.sv
module abg_ofs_map #(
  parameter int OFS_W = 2
) (
  input  abg_pkg::burst_order_e order,
  input  logic [OFS_W-1:0]      start,
  input  logic [OFS_W-1:0]      beat,
  output logic [OFS_W-1:0]      ofs
);
  logic [OFS_W-1:0] ofs_xor;
  logic [OFS_W-1:0] ofs_add;

  for (genvar b = 0; b < OFS_W; b++) begin : g_xor
    assign ofs_xor[b] = start[b] ^ beat[b];
  end

  assign ofs_add = start + beat;

  always_comb begin
    if (order == abg_pkg::ORD_INTERLEAVE) ofs = ofs_xor;
    else                                  ofs = ofs_add;
  end
endmodule

// File: rtl/abg_burst_addr.sv
module abg_burst_addr #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              adv_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [HI_W-1:0]  hi_q, hi_d;
  logic [OFS_W-1:0] start_q, start_d;
  logic [OFS_W-1:0] beat_d, beat_q;
  logic [OFS_W-1:0] ofs_d;
  abg_pkg::burst_order_e order;

  assign order = abg_pkg::burst_order_e'(ilv_mode);

  always_comb begin
    if (ld) begin
      hi_d    = addr_in[ADDR_W-1:OFS_W];
      start_d = addr_in[OFS_W-1:0];
    end else begin
      hi_d    = hi_q;
      start_d = start_q;
    end
  end

  abg_beat_cnt #(.OFS_W(OFS_W)) i_cnt (
    .clk(clk), .rst(rst), .ld(ld), .adv_n(adv_n),
    .beat_d(beat_d), .beat_q(beat_q)
  );

  abg_ofs_map #(.OFS_W(OFS_W)) i_map (
    .order(order), .start(start_d), .beat(beat_d), .ofs(ofs_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      start_q  <= '0;
      addr_out <= '0;
    end else begin
      hi_q     <= hi_d;
      start_q  <= start_d;
      addr_out <= {hi_d, ofs_d};
    end
  end

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(addr_out[ADDR_W-1:OFS_W])); // R1
  AST_LOAD_SHOWN: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr_out == $past(addr_in))); // R8
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> $stable(addr_out)); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat_q == '0)); // R9
  AST_BEAT0_IS_START: assert property (@(posedge clk) disable iff (rst)
    (beat_q == '0) |-> (addr_out[OFS_W-1:0] == start_q)); // R4
endmodule

// File: tb/test_abg_burst_addr.sv
module test_abg_burst_addr;
  logic        clk = 1'b0;
  logic        rst, ld, adv_n, ilv_mode;
  logic [14:0] addr_in;
  logic [14:0] addr_out;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  abg_burst_addr i_abg_burst_addr (
    .clk(clk), .rst(rst), .ld(ld), .adv_n(adv_n),
    .ilv_mode(ilv_mode), .addr_in(addr_in), .addr_out(addr_out)
  );

  // {req, rst, ld, adv_n, mode, addr_in, expected}
  localparam int NV = 23;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {4'd9, 1'b1,1'b0,1'b1,1'b1, 15'h0000, 15'h0000}, // R9 reset
    {4'd8, 1'b0,1'b1,1'b1,1'b1, 15'h4A31, 15'h4A31}, // R8 load shown
    {4'd2, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h4A30}, // R2 01->00
    {4'd5, 1'b0,1'b0,1'b1,1'b1, 15'h0000, 15'h4A30}, // R5 wait
    {4'd2, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h4A33}, // R2 ->11
    {4'd2, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h4A32}, // R2 ->10
    {4'd4, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h4A31}, // R4 wrap
    {4'd7, 1'b0,1'b1,1'b0,1'b1, 15'h0F56, 15'h0F56}, // R7 load beats advance
    {4'd7, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h0F57}, // R7 beat 1 after load
    {4'd6, 1'b0,1'b1,1'b1,1'b1, 15'h7FFF, 15'h7FFF}, // R6 mid-burst load
    {4'd6, 1'b0,1'b0,1'b0,1'b1, 15'h0000, 15'h7FFE}, // R6 restarted order
    {4'd9, 1'b1,1'b0,1'b1,1'b0, 15'h0000, 15'h0000}, // R9 reset
    {4'd8, 1'b0,1'b1,1'b1,1'b0, 15'h2223, 15'h2223}, // R8 load linear
    {4'd3, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h2220}, // R3 11->00
    {4'd3, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h2221}, // R3 ->01
    {4'd5, 1'b0,1'b0,1'b1,1'b0, 15'h0000, 15'h2221}, // R5 wait
    {4'd3, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h2222}, // R3 ->10
    {4'd4, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h2223}, // R4 wrap
    {4'd1, 1'b0,1'b0,1'b0,1'b0, 15'h5555, 15'h2220}, // R1 upper held
    {4'd7, 1'b0,1'b1,1'b0,1'b0, 15'h1001, 15'h1001}, // R7 load priority
    {4'd3, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h1002}, // R3 01->10
    {4'd9, 1'b1,1'b1,1'b0,1'b0, 15'h6666, 15'h0000}, // R9 reset over load
    {4'd9, 1'b0,1'b0,1'b0,1'b0, 15'h0000, 15'h0001}  // R9 beat was cleared
  };

  task automatic check(input int req, input logic [14:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL R%0d: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic step(input logic r, input logic l, input logic a,
                      input logic m, input logic [14:0] ain);
    @(negedge clk);
    rst = r; ld = l; adv_n = a; ilv_mode = m; addr_in = ain;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; ld = 1'b0; adv_n = 1'b1; ilv_mode = 1'b1; addr_in = '0;
    @(posedge clk); @(posedge clk); #1;
    check(9, 15'h0000); // R9 state after power-up reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33], VEC[i][32], VEC[i][31], VEC[i][30], VEC[i][29:15]);
      check(int'(VEC[i][37:34]), VEC[i][14:0]);
    end

    // R5: long run of wait cycles with a changing addr_in holds the address
    step(1'b0, 1'b1, 1'b1, 1'b1, 15'h3C02);
    check(8, 15'h3C02);
    for (int k = 0; k < 10; k++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, 15'(k * 97));
      check(5, 15'h3C02);
    end
    // R2 interleaved from start 10: 10,11,00,01, then R4 wrap to 10
    step(1'b0, 1'b0, 1'b0, 1'b1, 15'h0); check(2, 15'h3C03);
    step(1'b0, 1'b0, 1'b0, 1'b1, 15'h0); check(2, 15'h3C00);
    step(1'b0, 1'b0, 1'b0, 1'b1, 15'h0); check(2, 15'h3C01);
    step(1'b0, 1'b0, 1'b0, 1'b1, 15'h0); check(4, 15'h3C02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule